// File: doc/BRIEF.md
# Tagged Inter-Thread FIFO Cell

This block is one storage cell used by hardware threads to pass 64-bit words to each other. It holds a small circular queue, and the caller picks the semantics of each access with a view code. One view reaches the queue entries directly. One view exposes a status/tag word. Two views give pop/push semantics, one blocking and one non-blocking. The cell keeps an empty flag (E), a full flag (F) and a trap flag (T) next to the queue.

A blocking access that cannot proceed does not stall the cell. The cell records the requesting thread in a 64-bit waiting bitmap and raises a one-cycle block indication. A thread scheduler outside the cell parks that thread. The next pop or push access that does go ahead releases every recorded thread at once through a one-cycle wake vector.

The view code is 0 for direct access, 1 for the tag word, 2 for blocking pop/push and 3 for non-blocking pop/push. All results are registered. They appear on the outputs after the clock edge that samples the strobe.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the cell is empty with E=1, F=0, T=0, a fill count of zero, the queue flag set and the depth field set to log2 of the depth (default depth 8).
- R2: A read in view 1 returns the tag word: E at bit 0, F at bit 1, T at bit 16, the queue flag (always 1) at bit 17, the fill count from bit 18 upward, log2 depth from bit 28 upward, and zero elsewhere.
- R3: A write in view 1 loads T, E and F from data bits 16, 0 and 1 and changes nothing else; other data bits, including those over the count field, are ignored.
- R4: A read in view 0 returns the head entry without removing it. A write in view 0 replaces the newest entry when the fill count is nonzero; when the count is zero the write has no effect.
- R5: A read in views 2 or 3 that goes ahead with a nonzero count returns the head entry, removes it with the read pointer wrapping modulo the depth, clears F, and sets E when the count drops to zero. Entries leave in push order.
- R6: A write in views 2 or 3 that goes ahead with the count below the depth stores the word behind the newest entry, clears E, and sets F when the count reaches the depth.
- R7: In view 2, a read while E=1 or a write while F=1 is held. The queue and the flags are unchanged, the thread id bit is set in the waiting bitmap, the block output pulses for one cycle, and a held read returns zero.
- R8: A read or write in views 2 or 3 that is not held, while the waiting bitmap is nonzero, drives the whole bitmap onto the wake vector for exactly one cycle and clears the bitmap.
- R9: A view 3 read of an empty cell returns zero and changes neither count nor flags. A view 3 write to a full cell is dropped.
- R10: When read and write strobes are both high in the same cycle, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| view | input | 2 | Access view: 0 direct, 1 tag word, 2 blocking pop/push, 3 non-blocking pop/push |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Write data |
| threadId | input | 6 | Id of the requesting thread |
| rdData | output | 64 | Registered read result, held between reads |
| blocked | output | 1 | One-cycle pulse: the access was held |
| wakeVec | output | 64 | One-cycle pulse of released thread bits |

## Verification
The bench fills the queue to the depth and drains it again after the read pointer has been moved off zero. A design with a bad modulo or insertion index would return words out of order after the wrap.

It overwrites the newest entry through view 0 while the queue is full. A design that miscomputes the newest index would corrupt the head or a middle entry.

It holds two writers and then releases them together. It also loads F through view 1 while the count is zero, so that a blocking write is held on the flag rather than the count. A cell that keyed blocking off the count, leaked wake bits, or kept the bitmap after a release would show a wrong block or wake value.

It checks that view 3 accesses to an empty or full queue, view 0 writes to an empty queue, and simultaneous strobes leave the tag word unchanged. A design that let these accesses through would show a changed count or flag in that word.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;

  typedef enum logic [1:0] {
    VIEW_DIRECT = 2'd0,
    VIEW_TAG    = 2'd1,
    VIEW_EF_WAIT = 2'd2,
    VIEW_EF_TRY  = 2'd3
  } cellView_e;

  localparam int TAG_E_BIT     = 0;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_Q_BIT     = 17;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_DEPTH_LSB = 28;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic overwrite;
    logic loadRd;
    logic selHead;
    logic selTag;
  } cellStrb_t;

endpackage

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
  import itc_cell_pkg::*;
#(
  parameter int THREADS = 64,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cellView_e          view,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [2:0]         ctrlBits,   // {T, F, E} from write data
  input  logic [TID_W-1:0]   threadId,
  input  logic               cntZero,
  input  logic               cntOne,
  input  logic               cntFull,
  input  logic               cntLast,
  output cellStrb_t          strb,
  output logic               eFlag,
  output logic               fFlag,
  output logic               tFlag,
  output logic               blocked,
  output logic [THREADS-1:0] wakeVec,
  output logic [THREADS-1:0] blockedMap
);

  logic isRd, isWr, efView, waitView, stall, proceed, ctrlWr;

  always_comb begin
    isRd     = rdEn;
    isWr     = wrEn & ~rdEn;
    efView   = (view == VIEW_EF_WAIT) || (view == VIEW_EF_TRY);
    waitView = (view == VIEW_EF_WAIT);
    stall    = waitView & ((isRd & eFlag) | (isWr & fFlag));
    proceed  = efView & (isRd | isWr) & ~stall;
    ctrlWr   = isWr & (view == VIEW_TAG);

    strb.pop       = isRd & efView & ~stall & ~cntZero;
    strb.push      = isWr & efView & ~stall & ~cntFull;
    strb.overwrite = isWr & (view == VIEW_DIRECT) & ~cntZero;
    strb.loadRd    = isRd;
    strb.selHead   = isRd & ((view == VIEW_DIRECT) | strb.pop);
    strb.selTag    = isRd & (view == VIEW_TAG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eFlag      <= 1'b1;
      fFlag      <= 1'b0;
      tFlag      <= 1'b0;
      blocked    <= 1'b0;
      wakeVec    <= '0;
      blockedMap <= '0;
    end else begin
      blocked <= stall;
      wakeVec <= (proceed && (|blockedMap)) ? blockedMap : '0;

      if (stall)
        blockedMap <= blockedMap | (THREADS'(1) << threadId);
      else if (proceed)
        blockedMap <= '0;

      if (ctrlWr) begin
        tFlag <= ctrlBits[2];
        fFlag <= ctrlBits[1];
        eFlag <= ctrlBits[0];
      end else if (strb.pop) begin
        fFlag <= 1'b0;
        if (cntOne) eFlag <= 1'b1;
      end else if (strb.push) begin
        eFlag <= 1'b0;
        if (cntLast) fFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/itc_cell_dpath.sv
module itc_cell_dpath
  import itc_cell_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 3,
  localparam int DEPTH = 1 << DEPTH_LOG2,
  localparam int CW    = DEPTH_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cellStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eFlag,
  input  logic              fFlag,
  input  logic              tFlag,
  output logic              cntZero,
  output logic              cntOne,
  output logic              cntFull,
  output logic              cntLast,
  output logic [CW-1:0]     fillCount,
  output logic [DATA_W-1:0] rdData
);

  logic [DEPTH_LOG2-1:0] rdPtr, wrIdx, lastIdx;
  logic [CW-1:0]         count;
  logic [DATA_W-1:0]     entry [DEPTH];
  logic [DATA_W-1:0]     tagWord;

  always_comb begin
    wrIdx   = rdPtr + count[DEPTH_LOG2-1:0];
    lastIdx = wrIdx - 1'b1;
    cntZero = (count == '0);
    cntOne  = (count == CW'(1));
    cntFull = (count == CW'(DEPTH));
    cntLast = (count == CW'(DEPTH - 1));
    fillCount = count;

    tagWord = '0;
    tagWord[TAG_E_BIT] = eFlag;
    tagWord[TAG_F_BIT] = fFlag;
    tagWord[TAG_T_BIT] = tFlag;
    tagWord[TAG_Q_BIT] = 1'b1;
    tagWord[TAG_CNT_LSB +: CW] = count;
    tagWord[TAG_DEPTH_LSB +: 4] = 4'(DEPTH_LOG2);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[i] <= '0;
      else if (strb.push && (wrIdx == DEPTH_LOG2'(i)))
        entry[i] <= wrData;
      else if (strb.overwrite && (lastIdx == DEPTH_LOG2'(i)))
        entry[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (strb.pop) begin
        rdPtr <= rdPtr + 1'b1;
        count <= count - 1'b1;
      end else if (strb.push) begin
        count <= count + 1'b1;
      end
      if (strb.loadRd)
        rdData <= strb.selHead ? entry[rdPtr] : (strb.selTag ? tagWord : '0);
    end
  end

endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
  import itc_cell_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 3,
  parameter int THREADS    = 64,
  localparam int TID_W = $clog2(THREADS),
  localparam int CW    = DEPTH_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         view,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [TID_W-1:0]   threadId,
  output logic [DATA_W-1:0]  rdData,
  output logic               blocked,
  output logic [THREADS-1:0] wakeVec
);

  cellStrb_t          strb;
  logic               eFlag, fFlag, tFlag;
  logic               cntZero, cntOne, cntFull, cntLast;
  logic [CW-1:0]      fillCount;
  logic [THREADS-1:0] blockedMap;

  itc_cell_ctrl #(.THREADS(THREADS)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .view      (cellView_e'(view)),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .ctrlBits  ({wrData[TAG_T_BIT], wrData[TAG_F_BIT], wrData[TAG_E_BIT]}),
    .threadId  (threadId),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .cntFull   (cntFull),
    .cntLast   (cntLast),
    .strb      (strb),
    .eFlag     (eFlag),
    .fFlag     (fFlag),
    .tFlag     (tFlag),
    .blocked   (blocked),
    .wakeVec   (wakeVec),
    .blockedMap(blockedMap)
  );

  itc_cell_dpath #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .eFlag    (eFlag),
    .fFlag    (fFlag),
    .tFlag    (tFlag),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .cntFull  (cntFull),
    .cntLast  (cntLast),
    .fillCount(fillCount),
    .rdData   (rdData)
  );

endmodule

// File: rtl/itc_fifo_cell_chk.sv
module itc_fifo_cell_chk #(
  parameter int DEPTH_LOG2 = 3,
  parameter int THREADS    = 64,
  localparam int CW    = DEPTH_LOG2 + 1,
  localparam int DEPTH = 1 << DEPTH_LOG2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      fillCount,
  input logic               eFlag,
  input logic               fFlag,
  input logic               blocked,
  input logic [THREADS-1:0] wakeVec,
  input logic [THREADS-1:0] blockedMap
);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fillCount <= CW'(DEPTH));

  assert_empty_on_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fillCount == '0 && $past(fillCount) == CW'(1)) |-> eFlag);

  assert_full_on_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fillCount == CW'(DEPTH) && $past(fillCount) != CW'(DEPTH)) |-> fFlag);

  assert_held_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> $stable(fillCount));

  assert_wake_clears_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wakeVec) |-> (blockedMap == '0));

  assert_wake_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wakeVec) |=> (wakeVec == '0));

endmodule

bind itc_fifo_cell itc_fifo_cell_chk #(.DEPTH_LOG2(DEPTH_LOG2), .THREADS(THREADS)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fillCount (fillCount),
  .eFlag     (eFlag),
  .fFlag     (fFlag),
  .blocked   (blocked),
  .wakeVec   (wakeVec),
  .blockedMap(blockedMap)
);

// File: tb/tb_itc_fifo_cell.sv
module tb_itc_fifo_cell;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  view = 2'd0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [5:0]  threadId = '0;
  logic [63:0] rdData;
  logic        blocked;
  logic [63:0] wakeVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  itc_fifo_cell dut (
    .clk(clk), .rst_n(rst_n), .view(view), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .threadId(threadId), .rdData(rdData),
    .blocked(blocked), .wakeVec(wakeVec)
  );

  typedef struct {
    bit          chkRd;
    logic [63:0] expRd;
    bit          expBlk;
    logic [63:0] expWake;
    string       req;
  } item_t;

  item_t q[$];
  int nRun = 0, nFail = 0;
  bit done = 0;

  function automatic logic [63:0] tw(bit e, bit f, bit t, int cnt);
    return (64'd3 << 28) | (64'(cnt) << 18) | (64'd1 << 17) |
           (64'(t) << 16) | (64'(f) << 1) | 64'(e);
  endfunction

  task automatic acc(input logic [1:0] v, input bit r, input bit w,
                     input logic [63:0] d, input int tid, input bit chkRd,
                     input logic [63:0] eRd, input bit eBlk,
                     input logic [63:0] eWake, input string req);
    item_t it;
    @(negedge clk);
    view = v; rdEn = r; wrEn = w; wrData = d; threadId = 6'(tid);
    it.chkRd = chkRd; it.expRd = eRd; it.expBlk = eBlk;
    it.expWake = eWake; it.req = req;
    q.push_back(it);
  endtask

  task automatic tagRd(input logic [63:0] e, input string req);
    acc(2'd1, 1, 0, 0, 0, 1, e, 0, 0, req);
  endtask
  task automatic pushTry(input logic [63:0] d, input string req);
    acc(2'd3, 0, 1, d, 0, 0, 0, 0, 0, req);
  endtask
  task automatic popTry(input logic [63:0] e, input string req);
    acc(2'd3, 1, 0, 0, 0, 1, e, 0, 0, req);
  endtask

  // monitor: compare a quarter period after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        bit bad;
        it = q.pop_front();
        bad = 0;
        nRun++;
        if (it.chkRd && rdData !== it.expRd) begin
          $display("FAIL %s rdData actual=%h expected=%h", it.req, rdData, it.expRd);
          bad = 1;
        end
        if (blocked !== it.expBlk) begin
          $display("FAIL %s blocked actual=%0b expected=%0b", it.req, blocked, it.expBlk);
          bad = 1;
        end
        if (wakeVec !== it.expWake) begin
          $display("FAIL %s wakeVec actual=%h expected=%h", it.req, wakeVec, it.expWake);
          bad = 1;
        end
        if (bad) nFail++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tagRd(tw(1,0,0,0), "R1 reset tag");
    popTry(0, "R9 try pop empty");
    tagRd(tw(1,0,0,0), "R9 empty pop no change");

    for (int i = 1; i <= 8; i++) pushTry(64'h100 + 64'(i), "R6 push");
    tagRd(tw(0,1,0,8), "R6 R2 full tag");
    pushTry(64'hDEAD, "R9 push full");
    tagRd(tw(0,1,0,8), "R9 full push dropped");

    acc(2'd0, 1, 0, 0, 0, 1, 64'h101, 0, 0, "R4 direct read head");
    acc(2'd0, 1, 0, 0, 0, 1, 64'h101, 0, 0, "R4 direct read no pop");
    acc(2'd0, 0, 1, 64'h99, 0, 0, 0, 0, 0, "R4 direct overwrite");

    acc(2'd2, 0, 1, 64'hBAD, 5, 0, 0, 1, 0, "R7 held write t5");
    acc(2'd2, 0, 1, 64'hBAD, 9, 0, 0, 1, 0, "R7 held write t9");
    tagRd(tw(0,1,0,8), "R7 held no push");
    acc(2'd3, 1, 0, 0, 0, 1, 64'h101, 0, (64'd1 << 5) | (64'd1 << 9), "R8 R5 release");
    tagRd(tw(0,0,0,7), "R5 R8 after release");

    for (int i = 2; i <= 7; i++) popTry(64'h100 + 64'(i), "R5 pop order");
    popTry(64'h99, "R4 overwritten newest");
    tagRd(tw(1,0,0,0), "R5 drained");

    for (int i = 1; i <= 3; i++) pushTry(64'h200 + 64'(i), "R6 push");
    popTry(64'h201, "R5 pop");
    for (int i = 4; i <= 9; i++) pushTry(64'h200 + 64'(i), "R6 wrap push");
    tagRd(tw(0,1,0,8), "R6 full after wrap");
    for (int i = 2; i <= 9; i++) popTry(64'h200 + 64'(i), "R5 wrap pop");

    acc(2'd2, 1, 0, 0, 63, 1, 0, 1, 0, "R7 held read t63");
    acc(2'd2, 0, 1, 64'h55, 1, 0, 0, 0, 64'd1 << 63, "R8 release t63");
    acc(2'd2, 1, 0, 0, 1, 1, 64'h55, 0, 0, "R5 blocking pop");

    acc(2'd1, 0, 1, (64'd1 << 16) | (64'd1 << 17) | (64'd1 << 18) | 64'd2,
        0, 0, 0, 0, 0, "R3 tag write");
    tagRd(tw(0,1,1,0), "R3 only T E F");
    acc(2'd2, 0, 1, 64'h1, 2, 0, 0, 1, 0, "R7 held on F flag");
    tagRd(tw(0,1,1,0), "R7 flag held no push");
    acc(2'd3, 1, 0, 0, 0, 1, 0, 0, 64'd1 << 2, "R8 R9 try release");
    tagRd(tw(0,1,1,0), "R9 empty try no flag change");
    acc(2'd1, 0, 1, 64'h1, 0, 0, 0, 0, 0, "R3 tag write");
    tagRd(tw(1,0,0,0), "R3 restored");

    acc(2'd3, 1, 1, 64'h77, 0, 1, 0, 0, 0, "R10 both strobes");
    tagRd(tw(1,0,0,0), "R10 write ignored");
    acc(2'd0, 0, 1, 64'h88, 0, 0, 0, 0, 0, "R4 direct write empty");
    tagRd(tw(1,0,0,0), "R4 empty overwrite no effect");
    pushTry(64'h31, "R6 push");
    acc(2'd0, 1, 0, 0, 0, 1, 64'h31, 0, 0, "R4 direct read");
    popTry(64'h31, "R5 pop");

    @(negedge clk);
    rdEn = 0; wrEn = 0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule